// File: doc/BRIEF.md
# Serial Command Frame Receiver with Chain Output

This block is the serial slave front end of a small configurable peripheral. A host shifts 16-bit command words into it over a four-wire serial port: a serial clock, an active-low select, a data input and a data output. All port signals are brought into the system clock domain by synchronisers and sampled there. When the select line is released, the block looks at how many bits arrived in the frame. It then issues a decoded command as a one-cycle strobe, replays the previous command, or discards the frame.

The data output always carries the top bit of the 16-bit shift register. Several devices can therefore be chained, each output feeding the next device's input, and served by one long frame. Readback commands load a register value into the shift register, so that it leaves on the data output during the following frame. A small register bank stands in for the downstream settings. It holds a set of working registers and a set of stored registers.

Top module: `spi_frame_rx`

## Requirements
- R1: A frame is shifted in most-significant bit first. The decoded word splits into opcode = bits 15:12, address = bits 11:8 and data = bits 7:0, and these appear on `cmd_code`, `cmd_addr` and `cmd_data`.
- R2: A command is decoded only after the select line rises. `cmd_vld` is then high for exactly one system clock cycle.
- R3: A frame whose clock count is a nonzero multiple of 16 (16, 32, ...) is valid, and its last 16 bits are decoded. Any other nonzero count issues no command.
- R4: A frame whose count is not a multiple of 4 clears the shift register. A count that is a multiple of 4 but not of 16 leaves the shifted contents in place. In both cases the contents present at the start of the next frame are what shifts out on `ser_out`.
- R5: A select pulse with no clock edges replays the last valid command, with the same fields and the same effect, even after invalid frames in between.
- R6: Until the first valid frame after reset, a select pulse without clocks issues nothing.
- R7: `ser_out_en` is low whenever select is high. `ser_out` is the shift register's top bit and changes only on falling serial clock edges or at the start of a frame.
- R8: `ser_out` is the input delayed by 16 clocks. In a chain of two devices given a 32-bit frame, the first 16 bits reach the far device and the last 16 bits stay in the near device.
- R9: Opcode 0x0 changes no register. Opcode 0xB writes the data to working register [addr], and opcode 0x3 writes it to stored register [addr]. Writes to an address of NREG or above have no effect.
- R10: Opcode 0x9 (working) and opcode 0xA (stored) load {opcode, address, register value} into the shift register. An address of NREG or above reads as zero.
- R11: Both serial modes work: clock idle low and clock idle high. In each, data is sampled on the rising edge.
- R12: After reset `cmd_vld` and `ser_out_en` are low and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out (shift register top bit) |
| ser_out_en | output | 1 | Output drive enable, low releases the line |
| cmd_vld | output | 1 | One-cycle decoded command strobe |
| cmd_code | output | 4 | Decoded opcode |
| cmd_addr | output | 4 | Decoded address |
| cmd_data | output | 8 | Decoded data |

## Verification
Assertions check, on every cycle, the properties that hold at all times:
- the strobe lasts one cycle and only follows a select release;
- a no-clock pulse before the first valid frame stays silent, and a later one replays the stored word;
- the shift register moves only on rising serial edges or at frame end;
- the output drive is released while select is high;
- a no-operation leaves the register bank untouched.

The bench scenarios show the end-to-end outcomes: decoded field values, the frame-length cases (kept, cleared, 32-bit), readback contents shifted out in the next frame, both clock polarities, and the split of a 32-bit frame across two chained devices.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int WORD_W = CMD_W + ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int NIB_W  = $clog2(CMD_W);

  typedef enum logic [CMD_W-1:0] {
    OP_NOP      = 4'h0,
    OP_WR_STORE = 4'h3,
    OP_RD_WORK  = 4'h9,
    OP_RD_STORE = 4'hA,
    OP_WR_WORK  = 4'hB
  } op_e;

  typedef struct packed {
    logic [CMD_W-1:0]  op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= RST_VAL[i];
        q[i]      <= RST_VAL[i];
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
  import spi_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din,
  input  logic              clr,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_word,
  output logic [WORD_W-1:0] sr,
  output logic [CNT_W-1:0]  cnt,
  output logic              any_clk,
  output logic              dout,
  output logic              dout_en
);
  logic [WORD_W-1:0] sr_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              any_n, dout_n;

  always_comb begin
    sr_n   = sr;
    cnt_n  = cnt;
    any_n  = any_clk;
    dout_n = dout;
    if (cs_fall) begin
      cnt_n  = '0;
      any_n  = 1'b0;
      dout_n = sr[WORD_W-1];
    end else if (cs_act && sclk_rise) begin
      sr_n   = {sr[WORD_W-2:0], din};
      cnt_n  = cnt + 1'b1;
      any_n  = 1'b1;
    end else if (cs_act && sclk_fall) begin
      dout_n = sr[WORD_W-1];
    end
    if (cs_rise) begin
      if (ld)       sr_n = ld_word;
      else if (clr) sr_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      any_clk <= 1'b0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      sr      <= sr_n;
      cnt     <= cnt_n;
      any_clk <= any_n;
      dout    <= dout_n;
      dout_en <= cs_act;
    end
  end

  // R7: line released one cycle after select goes inactive
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !dout_en);
  // R3: shift register moves only on a rising serial edge or at frame end
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_act && sclk_rise) && !cs_rise) |=> $stable(sr));
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic              any_clk,
  input  logic [CNT_W-1:0]  cnt,
  input  frame_t            sr,
  input  logic [DATA_W-1:0] rd_val,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_store,
  output logic              ld,
  output logic [WORD_W-1:0] ld_word,
  output logic              clr,
  output logic              cmd_vld,
  output frame_t            cmd_word
);
  frame_t last, exec;
  logic   have_last, good, replay, fire, is_rd;
  logic   last_en, word_en;

  always_comb begin
    good     = any_clk && (cnt == '0);
    replay   = !any_clk && have_last;
    fire     = cs_rise && (good || replay);
    exec     = good ? sr : last;
    is_rd    = (exec.op == OP_RD_WORK) || (exec.op == OP_RD_STORE);
    rd_addr  = exec.addr;
    rd_store = (exec.op == OP_RD_STORE);
    ld       = fire && is_rd;
    ld_word  = {exec.op, exec.addr, rd_val};
    clr      = cs_rise && any_clk && (cnt[NIB_W-1:0] != '0);
    last_en  = cs_rise && good;
    word_en  = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last      <= '0;
      have_last <= 1'b0;
      cmd_word  <= '0;
      cmd_vld   <= 1'b0;
    end else begin
      cmd_vld <= fire;
      if (last_en) begin
        last      <= sr;
        have_last <= 1'b1;
      end
      if (word_en) cmd_word <= exec;
    end
  end

  // R2: strobe is a single cycle and always follows a select release
  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld);
  a_r2_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> $past(cs_rise));
  // R6: no replay before a first valid frame
  a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !any_clk && !have_last) |=> !cmd_vld);
  // R5: a clockless pulse reissues the stored word
  a_r5_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !any_clk && have_last) |=> (cmd_vld && cmd_word == $past(last)));
endmodule

// File: rtl/spi_rx_regstub.sv
module spi_rx_regstub
  import spi_rx_pkg::*;
#(
  parameter int NREG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  frame_t            word,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_store,
  output logic [DATA_W-1:0] rd_val
);
  logic [NREG-1:0][DATA_W-1:0] wk, st;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic wk_en, st_en;
    assign wk_en = wr_vld && (word.op == OP_WR_WORK)  && (word.addr == ADDR_W'(i));
    assign st_en = wr_vld && (word.op == OP_WR_STORE) && (word.addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wk[i] <= '0;
        st[i] <= '0;
      end else begin
        if (wk_en) wk[i] <= word.data;
        if (st_en) st[i] <= word.data;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_val = rd_store ? st[i] : wk[i];
    end
  end

  // R9: a no-operation leaves every register untouched
  a_r9_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && word.op == OP_NOP) |=> ($stable(wk) && $stable(st)));
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_rx_pkg::*;
#(
  parameter int NREG = 2
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              ser_out_en,
  output logic              cmd_vld,
  output logic [CMD_W-1:0]  cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rst_pipe <= 2'b00;
    else            rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic [2:0] sync_q;
  logic       sel_s, sclk_s, din_s, sel_d, sclk_d;

  spi_rx_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(sys_clk), .rst_n(rst_n_i),
    .d({ser_sel_n, ser_clk, ser_in}), .q(sync_q)
  );
  assign {sel_s, sclk_s, din_s} = sync_q;

  always_ff @(posedge sys_clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sel_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      sel_d  <= sel_s;
      sclk_d <= sclk_s;
    end
  end

  logic cs_act, cs_fall, cs_rise, sclk_rise, sclk_fall;
  assign cs_act    = !sel_s;
  assign cs_fall   = !sel_s && sel_d;
  assign cs_rise   = sel_s && !sel_d;
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;

  logic [WORD_W-1:0] sr, ld_word;
  logic [CNT_W-1:0]  cnt;
  logic              any_clk, clr, ld, rd_store;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_val;
  frame_t            cmd_word;

  spi_rx_shifter u_shift (
    .clk(sys_clk), .rst_n(rst_n_i), .cs_act(cs_act), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .din(din_s), .clr(clr), .ld(ld), .ld_word(ld_word), .sr(sr),
    .cnt(cnt), .any_clk(any_clk), .dout(ser_out), .dout_en(ser_out_en)
  );

  spi_rx_frame u_frame (
    .clk(sys_clk), .rst_n(rst_n_i), .cs_rise(cs_rise), .any_clk(any_clk),
    .cnt(cnt), .sr(sr), .rd_val(rd_val), .rd_addr(rd_addr),
    .rd_store(rd_store), .ld(ld), .ld_word(ld_word), .clr(clr),
    .cmd_vld(cmd_vld), .cmd_word(cmd_word)
  );

  spi_rx_regstub #(.NREG(NREG)) u_regs (
    .clk(sys_clk), .rst_n(rst_n_i), .wr_vld(cmd_vld), .word(cmd_word),
    .rd_addr(rd_addr), .rd_store(rd_store), .rd_val(rd_val)
  );

  assign cmd_code = cmd_word.op;
  assign cmd_addr = cmd_word.addr;
  assign cmd_data = cmd_word.data;

  // R7: while select is inactive for two cycles the line is released
  a_r7_quiet: assert property (@(posedge sys_clk) disable iff (!rst_n_i)
    (sel_s && sel_d) |-> !ser_out_en);
endmodule

// File: tb/sim_spi_frame_rx.sv
module sim_spi_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk, rst_n, sclk, sel_n, din;
  logic u0_out, u0_en, u0_vld, u1_out, u1_en, u1_vld;
  logic [3:0] u0_code, u0_addr, u1_code, u1_addr;
  logic [7:0] u0_data, u1_data;
  logic       u1_in;

  int checks = 0, errors = 0, en_bad = 0;
  int n0 = 0, n1 = 0;
  logic [15:0] last0 = '0, last1 = '0;

  assign u1_in = u0_en ? u0_out : 1'b1;

  spi_frame_rx u0 (.sys_clk(clk), .sys_rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n),
    .ser_in(din), .ser_out(u0_out), .ser_out_en(u0_en), .cmd_vld(u0_vld),
    .cmd_code(u0_code), .cmd_addr(u0_addr), .cmd_data(u0_data));
  spi_frame_rx u1 (.sys_clk(clk), .sys_rst_n(rst_n), .ser_clk(sclk), .ser_sel_n(sel_n),
    .ser_in(u1_in), .ser_out(u1_out), .ser_out_en(u1_en), .cmd_vld(u1_vld),
    .cmd_code(u1_code), .cmd_addr(u1_addr), .cmd_data(u1_data));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (u0_vld) begin n0++; last0 = {u0_code, u0_addr, u0_data}; end
    if (u1_vld) begin n1++; last1 = {u1_code, u1_addr, u1_data}; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] w, input int n, input bit m3,
                       output logic [31:0] got);
    got = '0;
    @(negedge clk);
    sclk = m3;
    repeat (HALF) @(negedge clk);
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      din  = w[n-1-i];
      repeat (HALF) @(negedge clk);
      got[n-1-i] = u0_out;
      if (!u0_en) en_bad++;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    if (!m3) sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (16) @(negedge clk);
    if (u0_en) en_bad++;
  endtask

  task automatic pulse();
    @(negedge clk);
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // Send a word, expect exactly one strobe with that word
  task automatic send16(input logic [15:0] w, input bit m3, input string req);
    logic [31:0] g;
    int b = n0;
    frame({16'h0, w}, 16, m3, g);
    check(n0 == b + 1, req, n0 - b, 1);
    check(last0 == w, req, last0, w);
  endtask

  // NOP frame capturing the shift-register contents
  task automatic capture(input bit m3, input logic [15:0] exp, input string req);
    logic [31:0] g;
    frame(32'h0, 16, m3, g);
    check(g[15:0] == exp, req, g[15:0], exp);
  endtask

  task automatic t_reset();
    int b = n0;
    check(u0_en == 1'b0 && u0_vld == 1'b0, "R12 idle outputs", {u0_en, u0_vld}, 0);
    pulse();
    check(n0 == b, "R6 no replay before first frame", n0 - b, 0);
    send16(16'h9000, 1'b0, "R12 read after reset");
    capture(1'b0, 16'h9000, "R12 working reg zero");
  endtask

  task automatic t_mode0_rw();
    send16(16'hB05A, 1'b0, "R1 write fields");
    send16(16'h9000, 1'b0, "R2 readback strobe");
    capture(1'b0, 16'h905A, "R10 working readback");
  endtask

  task automatic t_mode3();
    send16(16'h3133, 1'b1, "R11 stored write mode3");
    send16(16'hA100, 1'b1, "R11 stored read mode3");
    capture(1'b1, 16'hA133, "R10 stored readback mode3");
  endtask

  task automatic t_nop_range();
    send16(16'h00FF, 1'b0, "R9 nop strobe");
    send16(16'h9000, 1'b0, "R9 read after nop");
    capture(1'b0, 16'h905A, "R9 nop left reg");
    send16(16'hB7EE, 1'b0, "R9 out of range write");
    send16(16'h9700, 1'b0, "R10 out of range read");
    capture(1'b0, 16'h9700, "R10 out of range zero");
  endtask

  task automatic t_keep_clear();
    logic [31:0] g;
    int b;
    send16(16'hB1C3, 1'b0, "R4 setup");
    b = n0;
    frame(32'hABC, 12, 1'b0, g);
    check(n0 == b, "R3 12-bit frame ignored", n0 - b, 0);
    capture(1'b0, 16'h3ABC, "R4 contents kept");
    send16(16'hB1C3, 1'b0, "R4 setup");
    b = n0;
    frame(32'h1ABC, 13, 1'b0, g);
    check(n0 == b, "R3 13-bit frame ignored", n0 - b, 0);
    capture(1'b0, 16'h0000, "R4 contents cleared");
    b = n0;
    frame(32'hFFFFF, 20, 1'b0, g);
    check(n0 == b, "R3 20-bit frame ignored", n0 - b, 0);
  endtask

  task automatic t_replay();
    logic [31:0] g;
    int b;
    send16(16'hB155, 1'b0, "R5 setup");
    b = n0;
    pulse();
    check(n0 == b + 1, "R5 replay strobe", n0 - b, 1);
    check(last0 == 16'hB155, "R5 replay fields", last0, 16'hB155);
    send16(16'h9100, 1'b0, "R5 readback setup");
    frame(32'hDEF, 12, 1'b0, g);
    b = n0;
    pulse();
    check(n0 == b + 1 && last0 == 16'h9100, "R5 replay after bad frame", last0, 16'h9100);
    capture(1'b0, 16'h9155, "R5 replayed readback");
  endtask

  task automatic t_chain();
    logic [31:0] g;
    int b0 = n0, b1 = n1;
    frame(32'hB177_B022, 32, 1'b0, g);
    check(n0 == b0 + 1 && last0 == 16'hB022, "R3 32-bit near word", last0, 16'hB022);
    check(n1 == b1 + 1 && last1 == 16'hB177, "R8 far device word", last1, 16'hB177);
    check(g[15:0] == 16'hB177, "R8 pass-through delay", g[15:0], 16'hB177);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sel_n = 1'b1; din = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_mode0_rw();
    t_mode3();
    t_nop_range();
    t_keep_clear();
    t_replay();
    t_chain();
    check(en_bad == 0, "R7 drive enable follows select", en_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule